// File: doc/BRIEF.md
# Staged Chip-Select Timing Configuration Bank

This block holds the timing and operating-mode settings for a static memory controller with eight chip selects. The chip selects are arranged as two interfaces with four selects each. Software does not write a chip select's settings directly. It first loads a shared timing holding register and a shared mode holding register. It then writes a command word that names one chip select and asks for an update. That command copies both holding values into the named chip select's active registers in one step.

Because the holding registers are shared, they can be reloaded for the next chip select without disturbing any chip select that has already been committed. The active values of all eight chip selects are driven in parallel to a downstream memory-cycle engine. That engine, the external bus cycles and any device command sequences are outside this block.

Top module: `smc_cs_cfg_bank`

## Requirements
- R1: While `rst` is high at a rising clock edge, all active timing and mode values, both holding registers and the stored command word are cleared to zero.
- R2: A write to offset 0x14 stores bits 19:0 of the data in the timing holding register. A read of 0x14 returns that value with bits 31:20 as zero. The timing fields are: read cycle 3:0, write cycle 7:4, output-enable delay 11:8, write-enable delay 15:12, page cycle 19:16.
- R3: A write to offset 0x18 stores bits 11:0 of the data in the mode holding register. A read of 0x18 returns that value with bits 31:12 as zero. The mode fields are: width 1:0 (2 = 32-bit), synchronous read 2, read burst 5:3, synchronous write 6, write burst 9:7, address-valid enable 11.
- R4: A write to either holding register never changes any active chip-select output.
- R5: A write to offset 0x10 whose bits 22:21 equal 2'b10 (update) copies both holding values into chip select {bit 25, bits 24:23}. Bit 25 selects the interface and bits 24:23 select the chip select within it. The new values appear on the outputs right after the clock edge on which the command is written.
- R6: An update command leaves the active values of every other chip select unchanged.
- R7: A command whose bits 22:21 are 2'b00, 2'b01 or 2'b11 changes no active register.
- R8: A read of offset 0x10 returns the full 32-bit word that was last written there.
- R9: Rewriting the holding registers after an update leaves the values already committed to chip selects unchanged.
- R10: Chip select n drives its active timing on `cs_timing_o[n*20 +: 20]` and its active mode on `cs_mode_o[n*12 +: 12]`, using the same bit layouts as R2 and R3.
- R11: A write to any other offset changes no register, and a read of any other offset returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the register interface |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| cs_timing_o | output | 160 | Active timing values of all eight chip selects, 20 bits each |
| cs_mode_o | output | 96 | Active mode values of all eight chip selects, 12 bits each |

## Verification
A wrong holding value stays hidden from the active outputs until an update command commits it. It can be seen earlier by reading it back at 0x14 or 0x18 in the same cycle. A wrong target decode or a leaking update strobe corrupts some chip-select slice on the edge of the command write. The bench therefore compares all eight slices after every command, including the ignored types. Retained values are checked again after the holding registers are rewritten, so that an active register left open to the holding bus is caught.

// File: rtl/smc_cfg_pkg.sv
package smc_cfg_pkg;

    localparam int NUM_CS    = 8;
    localparam int CS_IDX_W  = $clog2(NUM_CS);
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 8;
    localparam int TIM_W     = 20;
    localparam int MODE_W    = 12;

    localparam logic [ADDR_W-1:0] OFS_CMD  = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_TIM  = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_MODE = 8'h18;

    // Command word layout: type field in bits 22:21,
    // target {interface, select} in bits 25:23.
    localparam int CMD_LSB   = 21;
    localparam int CMD_MSB   = 25;
    localparam int CMD_W     = CMD_MSB - CMD_LSB + 1;

    typedef enum logic [1:0] {
        CMD_T0     = 2'b00,
        CMD_T1     = 2'b01,
        CMD_UPDATE = 2'b10,
        CMD_T3     = 2'b11
    } cmd_type_e;

    typedef struct packed {
        logic [3:0] page_cyc;
        logic [3:0] we_dly;
        logic [3:0] oe_dly;
        logic [3:0] wr_cyc;
        logic [3:0] rd_cyc;
    } cs_timing_t;

    typedef struct packed {
        logic       adv_en;
        logic       rsvd;
        logic [2:0] wr_burst;
        logic       wr_sync;
        logic [2:0] rd_burst;
        logic       rd_sync;
        logic [1:0] width;
    } cs_mode_t;

    function automatic cmd_type_e cmd_kind(input logic [CMD_W-1:0] f);
        return cmd_type_e'(f[1:0]);
    endfunction

    function automatic logic [CS_IDX_W-1:0] cmd_target(input logic [CMD_W-1:0] f);
        return f[CMD_W-1:2];
    endfunction

endpackage

// File: rtl/smc_hold_regs.sv
module smc_hold_regs
    import smc_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output cs_timing_t        hold_tim,
    output cs_mode_t          hold_mode,
    output logic              cmd_wr
);

    logic [DATA_W-1:0] cmd_q;
    logic              tim_wr, mode_wr;

    assign tim_wr  = bus_we && (bus_addr == OFS_TIM);
    assign mode_wr = bus_we && (bus_addr == OFS_MODE);
    assign cmd_wr  = bus_we && (bus_addr == OFS_CMD);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_tim  <= '0;
            hold_mode <= '0;
            cmd_q     <= '0;
        end else begin
            if (tim_wr)  hold_tim  <= cs_timing_t'(bus_wdata[TIM_W-1:0]);
            if (mode_wr) hold_mode <= cs_mode_t'(bus_wdata[MODE_W-1:0]);
            if (cmd_wr)  cmd_q     <= bus_wdata;
        end
    end

    always_comb begin
        unique case (bus_addr)
            OFS_CMD:  bus_rdata = cmd_q;
            OFS_TIM:  bus_rdata = DATA_W'(hold_tim);
            OFS_MODE: bus_rdata = DATA_W'(hold_mode);
            default:  bus_rdata = '0;
        endcase
    end

    // R11: holding registers move only on a write to their own offset
    assert_hold_tim_stable_R11: assert property (@(posedge clk) disable iff (rst)
        !(bus_we && bus_addr == OFS_TIM) |=> $stable(hold_tim));
    assert_hold_mode_stable_R11: assert property (@(posedge clk) disable iff (rst)
        !(bus_we && bus_addr == OFS_MODE) |=> $stable(hold_mode));
    // R8: command readback follows the last command write
    assert_cmd_readback_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == OFS_CMD) |=> cmd_q == $past(bus_wdata));

endmodule

// File: rtl/smc_cmd_decode.sv
module smc_cmd_decode
    import smc_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_wr,
    input  logic [CMD_W-1:0]  cmd_field,
    output logic [NUM_CS-1:0] upd_vec
);

    cmd_type_e           kind;
    logic [CS_IDX_W-1:0] tgt;

    assign kind = cmd_kind(cmd_field);
    assign tgt  = cmd_target(cmd_field);

    always_comb begin
        upd_vec = '0;
        if (cmd_wr && kind == CMD_UPDATE)
            upd_vec = NUM_CS'(1) << tgt;
    end

    // R6: at most one chip select is strobed per command
    assert_single_target_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(upd_vec));
    // R7: no strobe without an update-type command write
    assert_no_strobe_other_R7: assert property (@(posedge clk) disable iff (rst)
        (!cmd_wr || cmd_field[1:0] != 2'b10) |-> upd_vec == '0);

endmodule

// File: rtl/smc_cs_regfile.sv
module smc_cs_regfile
    import smc_cfg_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_CS-1:0]        upd_vec,
    input  cs_timing_t               hold_tim,
    input  cs_mode_t                 hold_mode,
    output logic [NUM_CS*TIM_W-1:0]  cs_timing_o,
    output logic [NUM_CS*MODE_W-1:0] cs_mode_o
);

    cs_timing_t act_tim_q  [NUM_CS];
    cs_mode_t   act_mode_q [NUM_CS];

    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        always_ff @(posedge clk) begin
            if (rst) begin
                act_tim_q[i]  <= '0;
                act_mode_q[i] <= '0;
            end else if (upd_vec[i]) begin
                act_tim_q[i]  <= hold_tim;
                act_mode_q[i] <= hold_mode;
            end
        end

        assign cs_timing_o[i*TIM_W +: TIM_W]  = act_tim_q[i];
        assign cs_mode_o[i*MODE_W +: MODE_W]  = act_mode_q[i];

        // R5: a strobed chip select takes both holding values
        assert_commit_R5: assert property (@(posedge clk) disable iff (rst)
            upd_vec[i] |=> (cs_timing_o[i*TIM_W +: TIM_W] == $past(hold_tim))
                        && (cs_mode_o[i*MODE_W +: MODE_W] == $past(hold_mode)));
        // R4/R9: an unstrobed chip select keeps its settings
        assert_keep_R9: assert property (@(posedge clk) disable iff (rst)
            !upd_vec[i] |=> $stable(cs_timing_o[i*TIM_W +: TIM_W])
                         && $stable(cs_mode_o[i*MODE_W +: MODE_W]));
    end

endmodule

// File: rtl/smc_cs_cfg_bank.sv
module smc_cs_cfg_bank
    import smc_cfg_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     bus_we,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [DATA_W-1:0]        bus_wdata,
    output logic [DATA_W-1:0]        bus_rdata,
    output logic [NUM_CS*TIM_W-1:0]  cs_timing_o,
    output logic [NUM_CS*MODE_W-1:0] cs_mode_o
);

    cs_timing_t        hold_tim;
    cs_mode_t          hold_mode;
    logic              cmd_wr;
    logic [NUM_CS-1:0] upd_vec;

    smc_hold_regs u_hold (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .hold_tim  (hold_tim),
        .hold_mode (hold_mode),
        .cmd_wr    (cmd_wr)
    );

    smc_cmd_decode u_dec (
        .clk       (clk),
        .rst       (rst),
        .cmd_wr    (cmd_wr),
        .cmd_field (bus_wdata[CMD_MSB:CMD_LSB]),
        .upd_vec   (upd_vec)
    );

    smc_cs_regfile u_rf (
        .clk         (clk),
        .rst         (rst),
        .upd_vec     (upd_vec),
        .hold_tim    (hold_tim),
        .hold_mode   (hold_mode),
        .cs_timing_o (cs_timing_o),
        .cs_mode_o   (cs_mode_o)
    );

    // R1: the cycle after a reset edge everything reads as zero
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (cs_timing_o == '0) && (cs_mode_o == '0));

endmodule

// File: tb/smc_cs_cfg_bank_tb_top.sv
module smc_cs_cfg_bank_tb_top;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         bus_we = 1'b0;
    logic [7:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [159:0] cs_timing_o;
    logic [95:0]  cs_mode_o;

    int n_chk = 0;
    int n_fail = 0;

    logic [19:0] m_tim  [8];
    logic [11:0] m_mode [8];
    logic [19:0] m_htim;
    logic [11:0] m_hmode;
    logic [31:0] m_cmd;

    always #2 clk = ~clk;

    smc_cs_cfg_bank dut_i (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cs_timing_o(cs_timing_o), .cs_mode_o(cs_mode_o)
    );

    task automatic chk(input string req, input logic [159:0] act, input logic [159:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
        if (a == 8'h14) m_htim  = d[19:0];
        if (a == 8'h18) m_hmode = d[11:0];
        if (a == 8'h10) begin
            m_cmd = d;
            if (d[22:21] == 2'b10) begin
                m_tim[{d[25], d[24:23]}]  = m_htim;
                m_mode[{d[25], d[24:23]}] = m_hmode;
            end
        end
    endtask

    task automatic check_read(input string req, input logic [7:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(req, 160'(bus_rdata), 160'(exp));
    endtask

    task automatic check_outputs(input string req);
        logic [159:0] et;
        logic [95:0]  em;
        for (int i = 0; i < 8; i++) begin
            et[i*20 +: 20] = m_tim[i];
            em[i*12 +: 12] = m_mode[i];
        end
        chk({req, " timing"}, cs_timing_o, et);
        chk({req, " mode"}, 160'(cs_mode_o), 160'(em));
    endtask

    task automatic commit(input int cs, input logic [31:0] tim, input logic [31:0] md);
        bus_write(8'h14, tim);
        bus_write(8'h18, md);
        bus_write(8'h10, 32'h0040_0000 | (32'(cs) << 23));
    endtask

    task automatic t_reset;
        for (int i = 0; i < 8; i++) begin m_tim[i] = '0; m_mode[i] = '0; end
        m_htim = '0; m_hmode = '0; m_cmd = '0;
        check_outputs("R1 reset");
        check_read("R1 cmd reset", 8'h10, 32'h0);
        check_read("R1 tim reset", 8'h14, 32'h0);
        check_read("R1 mode reset", 8'h18, 32'h0);
    endtask

    task automatic t_holding_only;
        bus_write(8'h14, 32'h0002_393A);
        bus_write(8'h18, 32'h0000_0AAA);
        check_read("R2 tim readback", 8'h14, 32'h0002_393A);
        check_read("R3 mode readback", 8'h18, 32'h0000_0AAA);
        check_outputs("R4 holding write no effect");
        bus_write(8'h14, 32'hFFFF_FFFF);
        bus_write(8'h18, 32'hFFFF_FFFF);
        check_read("R2 tim upper bits zero", 8'h14, 32'h000F_FFFF);
        check_read("R3 mode upper bits zero", 8'h18, 32'h0000_0FFF);
        check_outputs("R4 holding write no effect all ones");
    endtask

    task automatic t_updates;
        commit(0, 32'h0002_393A, 32'h0000_0AAA);
        check_outputs("R5 R10 update cs0");
        commit(2, 32'h0002_7158, 32'h0000_0802);
        check_outputs("R6 update cs2 keeps cs0");
        commit(3, 32'h000C_D2AA, 32'h0000_0046);
        commit(4, 32'h0002_393A, 32'h0000_0AAA);
        check_outputs("R5 update cs4 interface 1");
        commit(7, 32'h0002_5156, 32'h0000_0046);
        commit(1, 32'h0004_9249, 32'h0000_0046);
        check_outputs("R6 R10 six chip selects");
        check_read("R8 last cmd", 8'h10, 32'h00C0_0000);
    endtask

    task automatic t_ignored_cmds;
        bus_write(8'h14, 32'h000A_BCDE);
        bus_write(8'h18, 32'h0000_0555);
        bus_write(8'h10, 32'h02C0_0000 ^ 32'h0040_0000);
        check_outputs("R7 type 00 ignored");
        bus_write(8'h10, 32'h02A0_0000);
        check_outputs("R7 type 01 ignored");
        bus_write(8'h10, 32'hFFE0_0000);
        check_outputs("R7 type 11 ignored");
        check_read("R8 cmd full word", 8'h10, 32'hFFE0_0000);
    endtask

    task automatic t_rewrite;
        bus_write(8'h14, 32'h0001_1111);
        bus_write(8'h18, 32'h0000_0123);
        check_outputs("R9 committed retained");
        bus_write(8'h10, 32'h02C0_0000);
        check_outputs("R9 R5 cs5 new values, others kept");
        bus_write(8'h10, 32'h0340_0000);
        check_outputs("R5 update cs6");
    endtask

    task automatic t_other_offsets;
        bus_write(8'h1C, 32'h1234_5678);
        bus_write(8'h00, 32'h0040_0000);
        check_read("R11 read unmapped 0x1C", 8'h1C, 32'h0);
        check_read("R11 read unmapped 0x04", 8'h04, 32'h0);
        check_read("R11 tim unchanged", 8'h14, 32'h0001_1111);
        check_read("R11 cmd unchanged", 8'h10, 32'h0340_0000);
        check_outputs("R11 outputs unchanged");
    endtask

    task automatic t_reset_again;
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        t_reset();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_holding_only();
        t_updates();
        t_ignored_cmds();
        t_rewrite();
        t_other_offsets();
        t_reset_again();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #100000;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule